// File: doc/BRIEF.md
# Serial Peripheral Master with Round-Robin Chip Selects

This block is a serial peripheral bus master. Words handed to it on a valid/ready stream are queued in a 32-entry, 16-bit transmit queue. The engine serialises each word onto MOSI, most significant bit first, while it drives SCK and one active-low chip select. At the same time it shifts MISO in and places the received frame, right-aligned, into a 32-entry receive queue. The receive queue is read out on a second valid/ready stream. The frame length runs from 4 to 16 bits. The bit clock comes from a prescaler counter in series with a rate divider, so each SCK level lasts H = (cfg_prescale+1)*(cfg_rate_div+1) module clocks.

Two addressing modes are provided. In the fixed mode, every frame goes to the slave that software names on `cfg_slave_sel`. In the round-robin mode, the block rotates the chip select by itself on every frame: slave 0, then 1, up to `cfg_seq_last`, then back to 0. It keeps doing this while the transmit queue holds data, so one queue can feed several slaves without software changing the selection. A loopback switch feeds the outgoing bits back into the receiver in place of MISO.

Back-pressure works as follows. A transmit word is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low when the transmit queue is full. The receive side holds `rx_valid` and `rx_data` steady until `rx_ready` is seen. The serial side has no back-pressure. A frame that completes while the receive queue is full is dropped, and `rx_overrun` is raised. Configuration inputs may change only while the block is idle.

Top module: `spim_seq_top`

## Requirements
- R1: After reset, every bit of cs_n is 1, sck and mosi are 0, tx_ready is 1, rx_valid is 0 and rx_overrun is 0.
- R2: Each queue holds 32 words of 16 bits. With cfg_enable low, tx_ready stays high for 32 accepted words and is low afterwards. While rx_valid is high and rx_ready is low, rx_data does not change.
- R3: A frame carries cfg_frame_len_m1+1 bits, i.e. that many SCK pulses under one chip select. Settings of 0, 1 or 2 are treated as 3, which gives a 4-bit frame.
- R4: Signalling uses SCK idle low. MOSI carries the frame's top bit, tx_data[len-1], from the moment the chip select falls, and each following bit, going downward, after each falling SCK edge. MISO is sampled on rising edges. The received bits fill rx_data from bit 0 upward, and the unused upper bits read 0.
- R5: Every SCK high and low phase, and the delay from the chip-select fall to the first rising edge, last exactly H = (cfg_prescale+1)*(cfg_rate_div+1) clocks. With both settings at 0, SCK therefore runs at half the module clock.
- R6: At most one cs_n bit is low at any time. In fixed mode, the low bit is cs_n[cfg_slave_sel].
- R7: In round-robin mode, successive frames select slaves 0, 1, ... up to cfg_seq_last and then wrap to 0. The rotation returns to slave 0 whenever cfg_seq_mode is low.
- R8: Between two frames, all of cs_n stays high for at least 2H clocks. SCK is low whenever no chip select is low.
- R9: With cfg_loopback high, the received frame equals the transmitted bits, and MISO is ignored.
- R10: A frame that completes while the receive queue is full is discarded and sets rx_overrun. The flag stays set until ovr_clear is pulsed. The 32 words already queued are unchanged.
- R11: While cfg_enable is low, no frame starts and queued transmit words are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | module clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_enable | input | 1 | allows frames to start |
| cfg_frame_len_m1 | input | 4 | frame length minus one |
| cfg_prescale | input | 8 | prescaler terminal count |
| cfg_rate_div | input | 8 | rate divider terminal count |
| cfg_seq_mode | input | 1 | 1 = round-robin chip selects |
| cfg_seq_last | input | 2 | highest slave index in the rotation |
| cfg_slave_sel | input | 2 | slave used in fixed mode |
| cfg_loopback | input | 1 | route transmit bits into the receiver |
| tx_valid | input | 1 | transmit word offered |
| tx_ready | output | 1 | transmit queue can accept |
| tx_data | input | 16 | transmit word, low bits used |
| rx_valid | output | 1 | received word available |
| rx_ready | input | 1 | consumer takes the received word |
| rx_data | output | 16 | received word, right-aligned |
| rx_overrun | output | 1 | sticky: a frame was dropped |
| ovr_clear | input | 1 | clears rx_overrun |
| sck | output | 1 | serial clock |
| mosi | output | 1 | serial data out |
| miso | input | 1 | serial data in |
| cs_n | output | 4 | active-low chip selects |

## Verification
Every cycle, the assertions check that at most one chip select is low, that SCK is low while no slave is selected, and that the chip selects do not move during an SCK high phase. They also check that a stalled receive word is held, that no frame starts while the block is disabled, and that a push into a full receive queue raises the overrun flag. The bench scenarios cover the remaining behaviour: bit order and exact phase lengths, the inter-frame gap, the round-robin order and wrap, the frame-length clamp, loopback, and the content of the receive queue across a full-queue drop. The bench model tracks these frame by frame.

// File: rtl/spim_seq_pkg.sv
package spim_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } eng_state_t;

  // smallest legal frame length minus one (4-bit frames)
  localparam int unsigned MIN_FRAME_M1 = 3;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push, pop;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !out_ready) |=> !in_ready);
endmodule

// File: rtl/spim_rate_gen.sv
module spim_rate_gen #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] prescale,
  input  logic [DIV_W-1:0] rate_div,
  output logic             tick
);
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             pre_end, div_end;

  assign pre_end = (pre_cnt == prescale);
  assign div_end = (div_cnt == rate_div);
  assign tick    = run && pre_end && div_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_end) begin
      pre_cnt <= '0;
      div_cnt <= div_end ? '0 : div_cnt + DIV_W'(1);
    end else begin
      pre_cnt <= pre_cnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_SS = 4,
  parameter int unsigned LEN_W  = $clog2(DATA_W),
  parameter int unsigned SS_W   = (NUM_SS > 1) ? $clog2(NUM_SS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [LEN_W-1:0]  frame_len_m1,
  input  logic              seq_mode,
  input  logic [SS_W-1:0]   seq_last,
  input  logic [SS_W-1:0]   slave_sel,
  input  logic              loopback,
  input  logic              tick,
  output logic              run,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] cs_n
);
  eng_state_t        state;
  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic [LEN_W-1:0]  bit_cnt, len_q, len_eff;
  logic [SS_W-1:0]   seq_ptr, cur_sel;
  logic [NUM_SS-1:0] sel_mask;
  logic              gap_half, start, rx_bit, last_fall;

  assign len_eff  = (frame_len_m1 < LEN_W'(MIN_FRAME_M1)) ? LEN_W'(MIN_FRAME_M1) : frame_len_m1;
  assign tx_ready = (state == ST_IDLE) && enable;
  assign start    = tx_ready && tx_valid;
  assign run      = (state != ST_IDLE);
  assign cur_sel  = seq_mode ? seq_ptr : slave_sel;
  assign rx_bit   = loopback ? tx_sh[DATA_W-1] : miso;
  assign mosi     = ((state == ST_LEAD) || (state == ST_SHIFT)) ? tx_sh[DATA_W-1] : 1'b0;
  assign last_fall = (state == ST_SHIFT) && tick && sck && (bit_cnt == len_q);
  assign rx_push  = last_fall;
  assign rx_word  = rx_sh;

  for (genvar i = 0; i < NUM_SS; i++) begin : g_sel
    assign sel_mask[i] = (cur_sel == SS_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_ptr <= '0;
    end else if (!seq_mode) begin
      seq_ptr <= '0;
    end else if (start) begin
      seq_ptr <= (seq_ptr == seq_last) ? '0 : seq_ptr + SS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tx_sh    <= '0;
      rx_sh    <= '0;
      bit_cnt  <= '0;
      len_q    <= '0;
      gap_half <= 1'b0;
      sck      <= 1'b0;
      cs_n     <= '1;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          tx_sh   <= tx_data << (LEN_W'(DATA_W - 1) - len_eff);
          rx_sh   <= '0;
          len_q   <= len_eff;
          bit_cnt <= '0;
          cs_n    <= ~sel_mask;
          state   <= ST_LEAD;
        end
        ST_LEAD: if (tick) begin
          sck   <= 1'b1;
          rx_sh <= {rx_sh[DATA_W-2:0], rx_bit};
          state <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (sck) begin
            sck <= 1'b0;
            if (bit_cnt == len_q) begin
              cs_n     <= '1;
              gap_half <= 1'b0;
              state    <= ST_GAP;
            end else begin
              bit_cnt <= bit_cnt + LEN_W'(1);
              tx_sh   <= tx_sh << 1;
            end
          end else begin
            sck   <= 1'b1;
            rx_sh <= {rx_sh[DATA_W-2:0], rx_bit};
          end
        end
        ST_GAP: if (tick) begin
          if (gap_half) state <= ST_IDLE;
          else          gap_half <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11
  no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && (state == ST_IDLE)) |=> ((state == ST_IDLE) && (&cs_n)));

  // R4
  cs_steady_sck_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(cs_n));
endmodule

// File: rtl/spim_seq_top.sv
module spim_seq_top #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned NUM_SS     = 4,
  parameter int unsigned PRE_W      = 8,
  parameter int unsigned DIV_W      = 8,
  localparam int unsigned LEN_W     = $clog2(DATA_W),
  localparam int unsigned SS_W      = (NUM_SS > 1) ? $clog2(NUM_SS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [LEN_W-1:0]  cfg_frame_len_m1,
  input  logic [PRE_W-1:0]  cfg_prescale,
  input  logic [DIV_W-1:0]  cfg_rate_div,
  input  logic              cfg_seq_mode,
  input  logic [SS_W-1:0]   cfg_seq_last,
  input  logic [SS_W-1:0]   cfg_slave_sel,
  input  logic              cfg_loopback,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_overrun,
  input  logic              ovr_clear,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] cs_n
);
  logic              txq_valid, eng_take, run, tick;
  logic [DATA_W-1:0] txq_data, rx_word;
  logic              rx_push, rxq_in_ready;

  spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .out_valid(txq_valid), .out_ready(eng_take), .out_data(txq_data)
  );

  spim_rate_gen #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(run),
    .prescale(cfg_prescale), .rate_div(cfg_rate_div), .tick(tick)
  );

  spim_engine #(.DATA_W(DATA_W), .NUM_SS(NUM_SS), .LEN_W(LEN_W), .SS_W(SS_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable),
    .frame_len_m1(cfg_frame_len_m1), .seq_mode(cfg_seq_mode),
    .seq_last(cfg_seq_last), .slave_sel(cfg_slave_sel), .loopback(cfg_loopback),
    .tick(tick), .run(run),
    .tx_valid(txq_valid), .tx_ready(eng_take), .tx_data(txq_data),
    .rx_push(rx_push), .rx_word(rx_word),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_push), .in_ready(rxq_in_ready), .in_data(rx_word),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rx_overrun <= 1'b0;
    else if (rx_push && !rxq_in_ready) rx_overrun <= 1'b1;
    else if (ovr_clear)              rx_overrun <= 1'b0;
  end

  // R10
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rxq_in_ready) |=> rx_overrun);

  // R6
  single_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R8
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sck);
endmodule

// File: tb/spim_seq_top_tb.sv
module spim_seq_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [3:0]  cfg_frame_len_m1 = 4'd7;
  logic [7:0]  cfg_prescale = 8'd0;
  logic [7:0]  cfg_rate_div = 8'd0;
  logic        cfg_seq_mode = 1'b0;
  logic [1:0]  cfg_seq_last = 2'd0;
  logic [1:0]  cfg_slave_sel = 2'd0;
  logic        cfg_loopback = 1'b0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] tx_data = 16'h0;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic [15:0] rx_data;
  logic        rx_overrun;
  logic        ovr_clear = 1'b0;
  logic        sck, mosi;
  logic        miso = 1'b0;
  logic [3:0]  cs_n;

  spim_seq_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .cfg_frame_len_m1(cfg_frame_len_m1), .cfg_prescale(cfg_prescale),
    .cfg_rate_div(cfg_rate_div), .cfg_seq_mode(cfg_seq_mode),
    .cfg_seq_last(cfg_seq_last), .cfg_slave_sel(cfg_slave_sel),
    .cfg_loopback(cfg_loopback), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_overrun(rx_overrun), .ovr_clear(ovr_clear),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model settings
  int cur_len = 8, cur_h = 1, cur_seq = 0, cur_last = 0, cur_sel = 0, cur_loop = 0;
  int bptr = 0;
  int q_tx[$], q_len[$], q_slv[$], q_rx[$], q_h[$];
  int rxq[$];
  bit exp_ovr = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int slv_pat(input int s);
    return (16'hA5C3 ^ (s * 16'h1111)) & 16'hFFFF;
  endfunction

  // ---------------- per-cycle monitor and slave model ----------------
  logic [3:0] prev_cs = 4'hF;
  logic       prev_sck = 1'b0;
  int cnt_edge = 0, gap_cnt = 0, bit_idx = 0;
  int f_tx = 0, f_len = 0, f_slv = 0, f_rx = 0, f_h = 1;
  bit in_frame = 1'b0, seen_frame = 1'b0;
  logic [15:0] sl_sh = 16'h0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cnt_edge++;
      if (&cs_n) gap_cnt++;
      chk($countones(~cs_n) <= 1, "R6", "chip selects low", int'(cs_n), 4'hE);
      chk(!((&cs_n) && sck), "R8", "sck while deselected", int'(sck), 0);
      // frame start
      if ((&prev_cs) && !(&cs_n)) begin
        if (q_tx.size() == 0) begin
          chk(1'b0, "R11", "unexpected frame", int'(cs_n), 4'hF);
        end else begin
          f_tx = q_tx.pop_front(); f_len = q_len.pop_front();
          f_slv = q_slv.pop_front(); f_rx = q_rx.pop_front(); f_h = q_h.pop_front();
          chk(cs_n == ~(4'b1 << f_slv), cur_seq ? "R7" : "R6", "selected slave",
              int'(cs_n), int'(~(4'b1 << f_slv)) & 15);
          if (seen_frame)
            chk(gap_cnt >= 2 * f_h, "R8", "gap clocks", gap_cnt, 2 * f_h);
          chk(mosi == ((f_tx >> (f_len - 1)) & 1), "R4", "first mosi bit",
              int'(mosi), (f_tx >> (f_len - 1)) & 1);
          sl_sh = 16'(slv_pat(f_slv) << (16 - f_len));
          miso = sl_sh[15];
          bit_idx = 0; cnt_edge = 0; in_frame = 1'b1; seen_frame = 1'b1;
        end
      end else if (in_frame) begin
        if (sck && !prev_sck) begin
          chk(cnt_edge == f_h, "R5", "low phase clocks", cnt_edge, f_h);
          chk(mosi == ((f_tx >> (f_len - 1 - bit_idx)) & 1), "R4", "mosi at rise",
              int'(mosi), (f_tx >> (f_len - 1 - bit_idx)) & 1);
          cnt_edge = 0;
        end
        if (!sck && prev_sck) begin
          chk(cnt_edge == f_h, "R5", "high phase clocks", cnt_edge, f_h);
          bit_idx++;
          cnt_edge = 0;
          sl_sh = sl_sh << 1;
          miso = sl_sh[15];
        end
        if (&cs_n) begin
          chk(bit_idx == f_len, "R3", "sck pulses in frame", bit_idx, f_len);
          if (rxq.size() < 32) rxq.push_back(f_rx);
          else exp_ovr = 1'b1;
          gap_cnt = 0; in_frame = 1'b0;
        end
      end
      prev_cs = cs_n;
      prev_sck = sck;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic set_mode(input int len_m1, input int pre, input int dv, input int seq,
                          input int last, input int sel, input int loop);
    @(negedge clk);
    cfg_frame_len_m1 = 4'(len_m1);
    cfg_prescale = 8'(pre); cfg_rate_div = 8'(dv);
    cfg_seq_mode = seq[0]; cfg_seq_last = 2'(last);
    cfg_slave_sel = 2'(sel); cfg_loopback = loop[0];
    cur_len = (len_m1 < 3) ? 4 : len_m1 + 1;
    cur_h = (pre + 1) * (dv + 1);
    cur_seq = seq; cur_last = last; cur_sel = sel; cur_loop = loop;
    if (!seq) bptr = 0;
  endtask

  task automatic push(input int d);
    int slv, mask;
    slv = cur_seq ? bptr : cur_sel;
    if (cur_seq) bptr = (bptr == cur_last) ? 0 : bptr + 1;
    mask = (1 << cur_len) - 1;
    @(negedge clk);
    tx_valid = 1'b1; tx_data = 16'(d);
    while (!tx_ready) @(negedge clk);
    q_tx.push_back(d & 16'hFFFF); q_len.push_back(cur_len); q_slv.push_back(slv);
    q_h.push_back(cur_h);
    q_rx.push_back(cur_loop ? (d & mask) : (slv_pat(slv) & mask));
    @(posedge clk); #1;
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while ((q_tx.size() != 0 || in_frame) && guard < 40000) begin
      @(negedge clk); guard++;
    end
    repeat (2 * cur_h + 4) @(negedge clk);
  endtask

  task automatic drain(input string req);
    int guard;
    while (rxq.size() != 0) begin
      guard = 0;
      @(negedge clk);
      while (!rx_valid && guard < 100) begin @(negedge clk); guard++; end
      chk(rx_valid, req, "rx_valid", int'(rx_valid), 1);
      chk(rx_data == 16'(rxq[0]), req, "rx word", int'(rx_data), rxq[0]);
      void'(rxq.pop_front());
      rx_ready = 1'b1;
      @(posedge clk); #1;
      rx_ready = 1'b0;
    end
    @(negedge clk);
    chk(!rx_valid, req, "rx queue empty", int'(rx_valid), 0);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n == 4'hF, "R1", "cs_n", int'(cs_n), 15);
    chk(!sck && !mosi, "R1", "sck/mosi", int'({sck, mosi}), 0);
    chk(tx_ready, "R1", "tx_ready", int'(tx_ready), 1);
    chk(!rx_valid && !rx_overrun, "R1", "rx_valid/overrun", int'({rx_valid, rx_overrun}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 / R11: fill while disabled, fixed slave 2, 8-bit frames, H=1
    set_mode(7, 0, 0, 0, 0, 2, 0);
    for (int i = 0; i < 32; i++) push(16'h3C00 + i * 7);
    repeat (40) @(negedge clk);
    chk(!tx_ready, "R2", "tx_ready when 32 queued", int'(tx_ready), 0);
    chk(cs_n == 4'hF, "R11", "no frame while disabled", int'(cs_n), 15);
    chk(q_tx.size() == 32, "R11", "frames kept", q_tx.size(), 32);
    cfg_enable = 1'b1;
    wait_idle();
    // R2 hold: rx word steady while not popped
    held = rx_data;
    repeat (5) @(negedge clk);
    chk(rx_data == held && rx_valid, "R2", "rx_data held", int'(rx_data), int'(held));
    drain("R6");

    // R7: round-robin over 3 slaves, 12-bit frames, H=6
    set_mode(11, 1, 2, 1, 2, 0, 0);
    for (int i = 0; i < 7; i++) push(16'h0F1 * (i + 3));
    wait_idle();
    drain("R7");

    // R7: rotation over all four, then switching mode off restarts at slave 0
    set_mode(5, 0, 1, 1, 3, 0, 0);
    for (int i = 0; i < 6; i++) push(16'h2A + i);
    wait_idle();
    set_mode(5, 0, 1, 0, 3, 1, 0);
    set_mode(5, 0, 1, 1, 3, 0, 0);
    push(16'h15);
    wait_idle();
    drain("R7");

    // R9: loopback, 16-bit frames, slave 3, H=2, miso still toggles but is ignored
    set_mode(15, 1, 0, 0, 0, 3, 1);
    push(16'hBEEF); push(16'h1234); push(16'h8001);
    wait_idle();
    drain("R9");

    // R3: length setting below legal range becomes 4 bits
    set_mode(0, 0, 0, 0, 0, 1, 0);
    push(16'hFFF6); push(16'h0009);
    wait_idle();
    drain("R3");

    // R10: 33 frames with receive side stalled
    set_mode(3, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 33; i++) push(i + 1);
    wait_idle();
    chk(exp_ovr, "R10", "model saw a drop", int'(exp_ovr), 1);
    chk(rx_overrun == exp_ovr, "R10", "overrun set", int'(rx_overrun), int'(exp_ovr));
    repeat (4) @(negedge clk);
    chk(rx_overrun, "R10", "overrun sticky", int'(rx_overrun), 1);
    @(negedge clk); ovr_clear = 1'b1;
    @(negedge clk); ovr_clear = 1'b0;
    chk(!rx_overrun, "R10", "overrun cleared", int'(rx_overrun), 0);
    drain("R10");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule